// File: doc/BRIEF.md
# Power-Up Hold and Stop-Mode Wake Sequencer

This block decides when the rest of the chip may run. When the supply indication says power is good, it holds the system reset for a fixed number of oscillator clocks. This gives the crystal time to settle. It then releases reset and raises a sticky power-up flag that software can read and clear.

The same block provides a stop mode. Software asks for it by setting a bit in the power control register. The core clock enable then drops, and the core stays frozen until one of two things happens. The first is a qualifying edge on one of four external interrupt pins. The second is the external reset pin. Either way, the same settle counter that serves power-up runs to its end before the core clock enable returns.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Register writes are single-cycle strobes. A strobe is accepted only while the core is running and out of reset. The raw oscillator clock is assumed to keep toggling throughout. The external reset and wake pins are assumed to be synchronous to that clock.

Top module: `pwrup_stop_seq`

## Requirements
- R1: After `pwr_ok` rises, `sys_rst` stays high for exactly 2**CNT_W rising clock edges. It is low after the 2**CNT_W-th edge. `core_clk_en` is low for that whole window and high after that edge.
- R2: `por_flag` becomes 1 on the same edge that ends the power-up hold. It reflects bit 6 of the reset status register (`cfg_sel`=1).
- R3: A write to the power control register (`cfg_sel`=0) with bit 1 set enters stop mode. From the next edge on, `stop_flag` is 1 and `core_clk_en` is 0.
- R4: In stop mode, only the configured edge on a wake pin starts the wake. Bits 0 and 2 of `wake_pins` wake on a rising edge. Bits 1 and 3 wake on a falling edge. The opposite edge leaves the block stopped.
- R5: After a valid wake edge is seen on edge E, `core_clk_en` returns to 1 after edge E+2**CNT_W. `stop_flag` clears on that same edge. `sys_rst` stays 0 throughout.
- R6: `ext_rst` is active high. While the core is running, `ext_rst` high makes `sys_rst` high from the next edge on, and `core_clk_en` stays 1. Reset is released on the first edge that samples `ext_rst` low.
- R7: `ext_rst` high during stop mode clears `stop_flag` on the next edge and restarts the settle count with `sys_rst` high. After 2**CNT_W further edges the core runs again. `por_flag` is not set by this path.
- R8: `por_flag` clears only on a write of 0 to bit 6 of the reset status register. A write of 1 leaves it unchanged. An external pin reset leaves it unchanged.
- R9: Register writes are ignored while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock, always running |
| pwr_ok | input | 1 | Power good; low is an asynchronous power-up reset of the block |
| ext_rst | input | 1 | External reset pin, active high, synchronous |
| cfg_wr | input | 1 | Single-cycle register write strobe |
| cfg_sel | input | 1 | 0 = power control register, 1 = reset status register |
| cfg_wdata | input | 8 | Write data; bit 1 = stop request, bit 6 = power-up flag |
| wake_pins | input | WAKE_N | External interrupt pins usable as stop-mode wake sources |
| sys_rst | output | 1 | Internal system reset, active high |
| core_clk_en | output | 1 | Enable for the gated core clock |
| por_flag | output | 1 | Sticky power-up flag |
| stop_flag | output | 1 | Stop request bit as seen by software |

## Verification
On every cycle, the embedded properties enforce several rules. The core clock is never enabled while the stop bit is set. Stop mode is left only after a wake edge or an external reset. The clock enable and the reset release follow only a completed settle count. The settle counter steps by one. The power-up flag rises only after a power-up hold and falls only after a software clear.

Other behaviour can only be shown by the bench scenarios. These cover the exact cycle lengths of the two settle windows. They cover the polarity of each wake pin: every pin is driven with both its wrong edge and its right edge. They also cover writes made while in reset being discarded, and the flag surviving a pin reset.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    PS_SETTLE = 2'd0,
    PS_RUN    = 2'd1,
    PS_STOP   = 2'd2,
    PS_PINRST = 2'd3
  } pseq_state_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned STOP_BIT = 1;
  localparam int unsigned FLAG_BIT = 6;

  localparam logic SEL_PWRCTL  = 1'b0;
  localparam logic SEL_RSTSTAT = 1'b1;

endpackage

// File: rtl/pwrseq_wake_edge.sv
module pwrseq_wake_edge #(
  parameter int unsigned        N         = 4,
  parameter logic [N-1:0]       RISE_MASK = 4'b0101
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] pins,
  output logic         hit
);

  logic [N-1:0] prev_q;
  logic [N-1:0] ev;

  // Reset to the idle level of each pin, so the first sample makes no false edge.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prev_q <= ~RISE_MASK;
    else        prev_q <= pins;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    if (RISE_MASK[i]) begin : g_rise
      assign ev[i] = pins[i] & ~prev_q[i];
    end else begin : g_fall
      assign ev[i] = ~pins[i] & prev_q[i];
    end
  end

  assign hit = |ev;

endmodule

// File: rtl/pwrseq_settle_cnt.sv
module pwrseq_settle_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic run,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run & (&cnt_q);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!por_n)
    (run && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

endmodule

// File: rtl/pwrseq_flags.sv
module pwrseq_flags (
  input  logic clk,
  input  logic por_n,
  input  logic set_por,
  input  logic clr_por,
  input  logic set_stop,
  input  logic clr_stop,
  output logic por_flag,
  output logic stop_flag
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       por_flag <= 1'b0;
    else if (set_por) por_flag <= 1'b1;
    else if (clr_por) por_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        stop_flag <= 1'b0;
    else if (clr_stop) stop_flag <= 1'b0;
    else if (set_stop) stop_flag <= 1'b1;
  end

  AST_PORF_RISE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_flag) |-> $past(set_por)); // R2
  AST_PORF_FALL: assert property (@(posedge clk) disable iff (!por_n)
    $fell(por_flag) |-> $past(clr_por)); // R8
  AST_STOP_RISE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(stop_flag) |-> $past(set_stop)); // R3

endmodule

// File: rtl/pwrup_stop_seq.sv
module pwrup_stop_seq
  import pwrseq_pkg::*;
#(
  parameter int unsigned          CNT_W     = 16,
  parameter int unsigned          WAKE_N    = 4,
  parameter logic [WAKE_N-1:0]    WAKE_RISE = 4'b0101
) (
  input  logic              clk_osc,
  input  logic              pwr_ok,
  input  logic              ext_rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [WAKE_N-1:0] wake_pins,
  output logic              sys_rst,
  output logic              core_clk_en,
  output logic              por_flag,
  output logic              stop_flag
);

  pseq_state_e state_q, state_d;
  logic settle_rst_q, settle_rst_d;
  logic por_pend_q, por_pend_d;

  logic wake_hit, settle_done, cnt_clr, cnt_run;
  logic sw_en, wr_stop, wr_flag0;
  logic set_por, clr_stop;

  pwrseq_wake_edge #(.N(WAKE_N), .RISE_MASK(WAKE_RISE)) u_wake (
    .clk   (clk_osc),
    .por_n (pwr_ok),
    .pins  (wake_pins),
    .hit   (wake_hit)
  );

  pwrseq_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk_osc),
    .por_n (pwr_ok),
    .clr   (cnt_clr),
    .run   (cnt_run),
    .done  (settle_done)
  );

  // Software access only while the core is clocked and out of reset.
  assign sw_en    = (state_q == PS_RUN) && !ext_rst;
  assign wr_stop  = sw_en && cfg_wr && (cfg_sel == SEL_PWRCTL) && cfg_wdata[STOP_BIT];
  assign wr_flag0 = sw_en && cfg_wr && (cfg_sel == SEL_RSTSTAT) && !cfg_wdata[FLAG_BIT];
  assign cnt_run  = (state_q == PS_SETTLE);

  always_comb begin
    state_d      = state_q;
    settle_rst_d = settle_rst_q;
    por_pend_d   = por_pend_q;
    cnt_clr      = 1'b0;
    set_por      = 1'b0;
    clr_stop     = 1'b0;
    unique case (state_q)
      PS_SETTLE: begin
        if (ext_rst && !settle_rst_q) begin
          cnt_clr      = 1'b1;
          settle_rst_d = 1'b1;
          clr_stop     = 1'b1;
        end else if (settle_done) begin
          state_d      = ext_rst ? PS_PINRST : PS_RUN;
          set_por      = por_pend_q;
          por_pend_d   = 1'b0;
          settle_rst_d = 1'b0;
          clr_stop     = 1'b1;
        end
      end
      PS_RUN: begin
        if (ext_rst)      state_d = PS_PINRST;
        else if (wr_stop) state_d = PS_STOP;
      end
      PS_STOP: begin
        if (ext_rst) begin
          state_d      = PS_SETTLE;
          cnt_clr      = 1'b1;
          settle_rst_d = 1'b1;
          clr_stop     = 1'b1;
        end else if (wake_hit) begin
          state_d      = PS_SETTLE;
          cnt_clr      = 1'b1;
          settle_rst_d = 1'b0;
        end
      end
      PS_PINRST: begin
        if (!ext_rst) state_d = PS_RUN;
      end
      default: state_d = PS_SETTLE;
    endcase
  end

  always_ff @(posedge clk_osc or negedge pwr_ok) begin
    if (!pwr_ok) begin
      state_q      <= PS_SETTLE;
      settle_rst_q <= 1'b1;
      por_pend_q   <= 1'b1;
    end else begin
      state_q      <= state_d;
      settle_rst_q <= settle_rst_d;
      por_pend_q   <= por_pend_d;
    end
  end

  pwrseq_flags u_flags (
    .clk       (clk_osc),
    .por_n     (pwr_ok),
    .set_por   (set_por),
    .clr_por   (wr_flag0),
    .set_stop  (wr_stop),
    .clr_stop  (clr_stop),
    .por_flag  (por_flag),
    .stop_flag (stop_flag)
  );

  assign sys_rst     = ((state_q == PS_SETTLE) && settle_rst_q) || (state_q == PS_PINRST);
  assign core_clk_en = (state_q == PS_RUN) || (state_q == PS_PINRST);

  AST_GATED_IN_STOP: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
    stop_flag |-> !core_clk_en); // R3
  AST_WAKE_SOURCE: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
    ((state_q == PS_SETTLE) && $past(state_q == PS_STOP)) |-> $past(wake_hit || ext_rst)); // R4
  AST_CLK_AFTER_COUNT: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
    $rose(core_clk_en) |-> $past(settle_done)); // R5
  AST_RELEASE_SOURCE: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
    $fell(sys_rst) |-> ($past(settle_done) || $past(state_q == PS_PINRST))); // R6
  AST_FLAG_POR_ONLY: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
    $rose(por_flag) |-> $past(por_pend_q)); // R7
  AST_NO_WRITE_IN_RST: assert property (@(posedge clk_osc) disable iff (!pwr_ok)
    sys_rst |=> !$rose(stop_flag)); // R9

endmodule

// File: tb/pwrup_stop_seq_bench.sv
module pwrup_stop_seq_bench;

  localparam int unsigned CW   = 4;
  localparam int unsigned HOLD = 1 << CW;
  localparam logic [3:0]  RISE = 4'b0101;

  logic       clk = 1'b0;
  logic       pwr_ok = 1'b0;
  logic       ext_rst = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [3:0] wake_pins = ~RISE;
  logic       sys_rst, core_clk_en, por_flag, stop_flag;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwrup_stop_seq #(.CNT_W(CW), .WAKE_N(4), .WAKE_RISE(RISE)) u_pwrup_stop_seq (
    .clk_osc     (clk),
    .pwr_ok      (pwr_ok),
    .ext_rst     (ext_rst),
    .cfg_wr      (cfg_wr),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .wake_pins   (wake_pins),
    .sys_rst     (sys_rst),
    .core_clk_en (core_clk_en),
    .por_flag    (por_flag),
    .stop_flag   (stop_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0; cfg_wdata = 8'h00;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // reset state while power is not good
    tick(); tick();
    chk("R1 rst in power-down", sys_rst, 1'b1);
    chk("R1 clk off in power-down", core_clk_en, 1'b0);
    chk("R2 flag clear in power-down", por_flag, 1'b0);
    chk("R3 stop clear in power-down", stop_flag, 1'b0);

    // R1/R2 power-up hold; R9 stop write held during hold is discarded
    pwr_ok = 1'b1;
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h02;
    for (int k = 1; k <= int'(HOLD); k++) begin
      tick();
      chk("R1 sys_rst in hold", sys_rst, (k < int'(HOLD)));
      chk("R1 clk_en in hold", core_clk_en, (k == int'(HOLD)));
      chk("R2 flag at hold end", por_flag, (k == int'(HOLD)));
      chk("R9 write in reset ignored", stop_flag, 1'b0);
      if (k == int'(HOLD) - 1) begin cfg_wr = 1'b0; cfg_wdata = 8'h00; end
    end
    tick();
    chk("R9 stop still clear", stop_flag, 1'b0);

    // R8 write of 1 keeps flag
    wr(1'b1, 8'hFF);
    chk("R8 write one keeps flag", por_flag, 1'b1);

    // R6 pin reset while running; R9 write during it ignored; R8 flag kept
    ext_rst = 1'b1;
    tick();
    chk("R6 sys_rst on pin", sys_rst, 1'b1);
    chk("R6 clk runs in pin reset", core_clk_en, 1'b1);
    wr(1'b0, 8'h02);
    chk("R9 stop write in pin reset", stop_flag, 1'b0);
    wr(1'b1, 8'h00);
    chk("R9 flag write in pin reset", por_flag, 1'b1);
    ext_rst = 1'b0;
    tick();
    chk("R6 release", sys_rst, 1'b0);
    chk("R8 flag survives pin reset", por_flag, 1'b1);

    // R8 clear by writing 0
    wr(1'b1, 8'hBF);
    chk("R8 write zero clears", por_flag, 1'b0);

    // R3/R4/R5 sweep over every wake pin, wrong edge then right edge
    for (int p = 0; p < 4; p++) begin
      wake_pins[p] = RISE[p];
      tick();
      chk("R4 pin move while running", core_clk_en, 1'b1);
      wr(1'b0, 8'h02);
      chk("R3 clock gated", core_clk_en, 1'b0);
      chk("R3 stop bit set", stop_flag, 1'b1);
      tick(); tick();
      chk("R3 stays gated", core_clk_en, 1'b0);
      wake_pins[p] = ~RISE[p];
      tick(); tick(); tick();
      chk("R4 wrong edge no wake", core_clk_en, 1'b0);
      chk("R4 wrong edge stop held", stop_flag, 1'b1);
      wake_pins[p] = RISE[p];
      tick();
      chk("R5 gated at wake edge", core_clk_en, 1'b0);
      for (int k = 1; k <= int'(HOLD); k++) begin
        tick();
        chk("R5 clk_en in wake count", core_clk_en, (k == int'(HOLD)));
        chk("R5 stop bit in wake count", stop_flag, (k != int'(HOLD)));
        chk("R5 no reset on wake", sys_rst, 1'b0);
      end
      wake_pins[p] = ~RISE[p];
      tick();
    end

    // R7 pin reset exits stop with settle count, flag not set
    wr(1'b0, 8'h02);
    chk("R7 stopped", stop_flag, 1'b1);
    ext_rst = 1'b1;
    tick();
    chk("R7 stop cleared", stop_flag, 1'b0);
    chk("R7 reset asserted", sys_rst, 1'b1);
    chk("R7 clock still gated", core_clk_en, 1'b0);
    for (int k = 1; k <= int'(HOLD); k++) begin
      tick();
      if (k == 1) ext_rst = 1'b0;
      chk("R7 sys_rst in restart", sys_rst, (k < int'(HOLD)));
      chk("R7 clk_en in restart", core_clk_en, (k == int'(HOLD)));
      chk("R7 flag not set by pin", por_flag, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule